// File: doc/BRIEF.md
# UART interrupt priority identifier

This block collects the interrupt sources of one UART channel, holds each in its own pending flag, and drives one active-high interrupt line. It also presents a 6-bit identification code that names the most urgent pending source. Event strobes come from the receiver, the transmitter, the modem-status logic and the flow-control character detector. The flow-control pins are watched directly. Software register accesses arrive as one-cycle strobes, and each pending flag clears on the access that belongs to its source.

Seven sources share six priority levels. Receive timeout and receive data both sit at the second level, each with its own code, and the timeout code is reported first. The flow-character source has two parts: an Xoff part, which clears when an Xon character arrives, and a special-character part, which clears on a line-status read. Some sources are levels, such as the line-error summary and the receive data available condition. These sources set their flag again on every cycle the level stays high.

Top module: `uart_irq_ident`

## Requirements
- R1: When no enabled source is pending, `irq_o` is 0 and `iir_code_o` is 6'h01. This is also the state right after reset.
- R2: The reported code is that of the highest pending source. The order, from highest to lowest, is: line status 6'h06, receive timeout 6'h0C, receive data 6'h04, transmit holding empty 6'h02, modem status 6'h00, Xoff/special character 6'h10, flow-pin deassertion 6'h20. Timeout is reported ahead of receive data when both are pending.
- R3: The enable bits of `ier_i` map to sources as follows: bit0 covers receive data and timeout, bit1 transmit empty, bit2 line status, bit3 modem status, bit4 Xoff/special, bit5 flow pins. A source whose bit is 0 never pends and never raises `irq_o`. Clearing a bit drops that source's pending flag at the next edge. With `ier_i` all zero, `irq_o` stays 0.
- R4: `thr_empty_evt_i` sets the transmit-empty flag. The flag clears on `thr_wr_i`, or on `iir_rd_i` in a cycle where code 6'h02 is being reported. An identification read that reports another code leaves the flag set.
- R5: `modem_evt_i` sets the modem flag, and `msr_rd_i` clears it.
- R6: A low-to-high transition on `cts_n_i` or `rts_n_i` sets the flow flag. A high-to-low transition does not. The flag clears on `iir_rd_i` while code 6'h20 is reported.
- R7: `xoff_evt_i` sets a flag that only `xon_evt_i` clears. `special_evt_i` sets a flag that only `lsr_rd_i` clears. Either flag produces code 6'h10.
- R8: `rx_timeout_evt_i` sets the timeout flag. `rx_avail_i` (a level) sets the receive-data flag. `rhr_rd_i` clears both flags.
- R9: The line-status flag is set by `overrun_evt_i`, and also on every cycle that the level `line_err_i` is high. `lsr_rd_i` clears it, but the flag sets again while `line_err_i` stays high.
- R10: A set or clear sampled at a clock edge shows on `irq_o`/`iir_code_o` right after that edge. If a source is set and cleared in the same cycle, the set wins.
- R11: Synchronous active-high `rst` clears every flag. It also treats both flow pins as previously inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 6 | Per-source enable bits |
| line_err_i | input | 1 | Level: receive error present in receive buffer |
| overrun_evt_i | input | 1 | Strobe: receive overrun |
| rx_timeout_evt_i | input | 1 | Strobe: stale receive data timeout |
| rx_avail_i | input | 1 | Level: receive data at or above threshold |
| thr_empty_evt_i | input | 1 | Strobe: transmit holding space available |
| modem_evt_i | input | 1 | Strobe: modem input delta |
| xoff_evt_i | input | 1 | Strobe: Xoff character received |
| xon_evt_i | input | 1 | Strobe: Xon character received |
| special_evt_i | input | 1 | Strobe: special character received |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| rts_n_i | input | 1 | Request-to-send pin, active low |
| iir_rd_i | input | 1 | Strobe: identification register read |
| lsr_rd_i | input | 1 | Strobe: line status register read |
| msr_rd_i | input | 1 | Strobe: modem status register read |
| rhr_rd_i | input | 1 | Strobe: receive holding register read |
| thr_wr_i | input | 1 | Strobe: transmit holding register write |
| irq_o | output | 1 | Interrupt active |
| iir_code_o | output | 6 | Identification code of top pending source |

## Verification
The assertions check several properties on every cycle:
- the idle code whenever the line is low;
- the timeout-before-data ordering;
- silence after all enables are zero;
- that each dedicated access clears its own flag;
- that an Xoff flag survives anything except Xon;
- that a held line error keeps the line-status flag set.

Some behaviour can only be shown by the bench's scenarios. One case is the full ranking of all seven sources across every enable mask and every combination of events, walked down by clearing each reported source in turn. Others are the reported-only effect of an identification read, the pin-edge direction, and the split clearing of Xoff versus special characters.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int CODE_W   = 6;
    localparam int IER_W    = 6;
    localparam int NUM_SRC  = 8;
    localparam int NUM_FLOW = 2;

    // pending-flag indices, highest priority first
    localparam int IX_LS   = 0;
    localparam int IX_TO   = 1;
    localparam int IX_RD   = 2;
    localparam int IX_THR  = 3;
    localparam int IX_MS   = 4;
    localparam int IX_XOFF = 5;
    localparam int IX_SPEC = 6;
    localparam int IX_FLOW = 7;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;
    localparam int EN_XS   = 4;
    localparam int EN_FLOW = 5;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE = 6'h01,
        CODE_LS   = 6'h06,
        CODE_TO   = 6'h0C,
        CODE_RD   = 6'h04,
        CODE_THR  = 6'h02,
        CODE_MS   = 6'h00,
        CODE_XS   = 6'h10,
        CODE_FLOW = 6'h20
    } iir_code_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic src_vec_t expand_enables(input logic [IER_W-1:0] ier);
        src_vec_t v;
        v[IX_LS]   = ier[EN_LS];
        v[IX_TO]   = ier[EN_RX];
        v[IX_RD]   = ier[EN_RX];
        v[IX_THR]  = ier[EN_THR];
        v[IX_MS]   = ier[EN_MS];
        v[IX_XOFF] = ier[EN_XS];
        v[IX_SPEC] = ier[EN_XS];
        v[IX_FLOW] = ier[EN_FLOW];
        return v;
    endfunction

    function automatic iir_code_e rank_code(input src_vec_t p);
        if (p[IX_LS])                     return CODE_LS;
        else if (p[IX_TO])                return CODE_TO;
        else if (p[IX_RD])                return CODE_RD;
        else if (p[IX_THR])               return CODE_THR;
        else if (p[IX_MS])                return CODE_MS;
        else if (p[IX_XOFF] | p[IX_SPEC]) return CODE_XS;
        else if (p[IX_FLOW])              return CODE_FLOW;
        else                              return CODE_NONE;
    endfunction

endpackage

// File: rtl/uirq_edge_rise.sv
module uirq_edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b1;
            else     prev[i] <= pin_n[i];
        end
        assign rise[i] = pin_n[i] & ~prev[i];
    end
endmodule

// File: rtl/uirq_src_latch.sv
module uirq_src_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= en[i] & (set[i] | (q[i] & ~clr[i]));
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            (en[i] && set[i]) |=> q[i]);                          // R10
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q[i]);                       // R10
    end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  src_vec_t                pend,
    output logic                    irq,
    output logic [CODE_W-1:0]       code
);
    always_comb begin
        irq  = |pend;
        code = rank_code(pend);
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        ier_i,
    input  logic              line_err_i,
    input  logic              overrun_evt_i,
    input  logic              rx_timeout_evt_i,
    input  logic              rx_avail_i,
    input  logic              thr_empty_evt_i,
    input  logic              modem_evt_i,
    input  logic              xoff_evt_i,
    input  logic              xon_evt_i,
    input  logic              special_evt_i,
    input  logic              cts_n_i,
    input  logic              rts_n_i,
    input  logic              iir_rd_i,
    input  logic              lsr_rd_i,
    input  logic              msr_rd_i,
    input  logic              rhr_rd_i,
    input  logic              thr_wr_i,
    output logic              irq_o,
    output logic [5:0]        iir_code_o
);
    logic [NUM_FLOW-1:0] flow_rise;
    src_vec_t            en_vec, src_set, src_clr, src_q, pend_g;

    uirq_edge_rise #(.N(NUM_FLOW)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_n ({rts_n_i, cts_n_i}),
        .rise  (flow_rise)
    );

    always_comb begin
        en_vec = expand_enables(ier_i);

        src_set            = '0;
        src_set[IX_LS]     = overrun_evt_i | line_err_i;
        src_set[IX_TO]     = rx_timeout_evt_i;
        src_set[IX_RD]     = rx_avail_i;
        src_set[IX_THR]    = thr_empty_evt_i;
        src_set[IX_MS]     = modem_evt_i;
        src_set[IX_XOFF]   = xoff_evt_i;
        src_set[IX_SPEC]   = special_evt_i;
        src_set[IX_FLOW]   = |flow_rise;

        // code is sampled at the read: only the reported source clears
        src_clr            = '0;
        src_clr[IX_LS]     = lsr_rd_i;
        src_clr[IX_TO]     = rhr_rd_i;
        src_clr[IX_RD]     = rhr_rd_i;
        src_clr[IX_THR]    = thr_wr_i | (iir_rd_i && iir_code_o == CODE_THR);
        src_clr[IX_MS]     = msr_rd_i;
        src_clr[IX_XOFF]   = xon_evt_i;
        src_clr[IX_SPEC]   = lsr_rd_i;
        src_clr[IX_FLOW]   = iir_rd_i && iir_code_o == CODE_FLOW;
    end

    uirq_src_latch #(.N(NUM_SRC)) u_latch (
        .clk (clk),
        .rst (rst),
        .en  (en_vec),
        .set (src_set),
        .clr (src_clr),
        .q   (src_q)
    );

    assign pend_g = src_q & en_vec;

    uirq_prio u_prio (
        .pend (pend_g),
        .irq  (irq_o),
        .code (iir_code_o)
    );

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> iir_code_o == CODE_NONE);                                  // R1
    AST_TO_BEFORE_RD: assert property (@(posedge clk) disable iff (rst)
        pend_g[IX_TO] |-> iir_code_o != CODE_RD);                             // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (ier_i == '0) |=> !irq_o);                                            // R3
    AST_THR_WR_CLR: assert property (@(posedge clk) disable iff (rst)
        (thr_wr_i && !thr_empty_evt_i) |=> !src_q[IX_THR]);                   // R4
    AST_MS_CLR: assert property (@(posedge clk) disable iff (rst)
        (msr_rd_i && !modem_evt_i) |=> !src_q[IX_MS]);                        // R5
    AST_FLOW_CLR: assert property (@(posedge clk) disable iff (rst)
        (iir_rd_i && iir_code_o == CODE_FLOW && flow_rise == '0)
            |=> !src_q[IX_FLOW]);                                             // R6
    AST_XOFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src_q[IX_XOFF] && !xon_evt_i && ier_i[EN_XS]) |=> src_q[IX_XOFF]);   // R7
    AST_RHR_CLR: assert property (@(posedge clk) disable iff (rst)
        (rhr_rd_i && !rx_timeout_evt_i) |=> !src_q[IX_TO]);                   // R8
    AST_LS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (line_err_i && ier_i[EN_LS]) |=> src_q[IX_LS]);                       // R9
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    logic rst;
    logic [5:0] ier;
    logic line_err, overrun, rx_to, rx_avail, thr_empty, modem, xoff, xon, special;
    logic cts_n, rts_n, iir_rd, lsr_rd, msr_rd, rhr_rd, thr_wr;
    logic irq;
    logic [5:0] code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .ier_i(ier),
        .line_err_i(line_err), .overrun_evt_i(overrun), .rx_timeout_evt_i(rx_to),
        .rx_avail_i(rx_avail), .thr_empty_evt_i(thr_empty), .modem_evt_i(modem),
        .xoff_evt_i(xoff), .xon_evt_i(xon), .special_evt_i(special),
        .cts_n_i(cts_n), .rts_n_i(rts_n), .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd),
        .msr_rd_i(msr_rd), .rhr_rd_i(rhr_rd), .thr_wr_i(thr_wr),
        .irq_o(irq), .iir_code_o(code)
    );

    // expected model indices: 0 LS,1 TO,2 RD,3 THR,4 MS,5 XOFF,6 SPEC,7 FLOW
    function automatic logic [5:0] exp_code(input logic [7:0] p);
        if (p[0]) return 6'h06;
        if (p[1]) return 6'h0C;
        if (p[2]) return 6'h04;
        if (p[3]) return 6'h02;
        if (p[4]) return 6'h00;
        if (p[5] | p[6]) return 6'h10;
        if (p[7]) return 6'h20;
        return 6'h01;
    endfunction

    function automatic int en_bit(input int idx);
        case (idx)
            0: return 2;
            1, 2: return 0;
            3: return 1;
            4: return 3;
            5, 6: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic check(input string req, input logic [5:0] ec, input logic ei);
        n_tests++;
        if (code !== ec || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b", req, code, irq, ec, ei);
        end
    endtask

    task automatic idle_inputs;
        line_err = 0; overrun = 0; rx_to = 0; rx_avail = 0; thr_empty = 0;
        modem = 0; xoff = 0; xon = 0; special = 0;
        iir_rd = 0; lsr_rd = 0; msr_rd = 0; rhr_rd = 0; thr_wr = 0;
    endtask

    task automatic tick;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset;
        idle_inputs(); cts_n = 1; rts_n = 1; rst = 1;
        tick();
        rst = 0;
    endtask

    task automatic sweep_one(input logic [5:0] en, input logic [6:0] ev);
        logic [7:0] p;
        do_reset();
        ier = en;
        rts_n = ev[6] ? 1'b0 : 1'b1;
        tick();
        overrun = ev[0]; rx_to = ev[1]; rx_avail = ev[2]; thr_empty = ev[3];
        modem = ev[4]; xoff = ev[5]; rts_n = 1'b1;
        tick();
        p = {ev[6], 1'b0, ev[5:0]};
        for (int i = 0; i < 8; i++) if (!en[en_bit(i)]) p[i] = 1'b0;
        for (int step = 0; step < 9; step++) begin
            logic [5:0] ec;
            ec = exp_code(p);
            check("R2 sweep", ec, |p);
            if (p == 8'h00) break;
            case (ec)
                6'h06: begin lsr_rd = 1; p[0] = 0; p[6] = 0; end
                6'h0C: begin rhr_rd = 1; p[1] = 0; p[2] = 0; end
                6'h04: begin rhr_rd = 1; p[2] = 0; end
                6'h02: begin iir_rd = 1; p[3] = 0; end
                6'h00: begin msr_rd = 1; p[4] = 0; end
                6'h10: if (p[5]) begin xon = 1; p[5] = 0; end
                       else begin lsr_rd = 1; p[6] = 0; p[0] = 0; end
                default: begin iir_rd = 1; p[7] = 0; end
            endcase
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        ier = 6'h3F;
        do_reset();
        check("R1 R11 reset idle", 6'h01, 0);

        // R9: level line error re-raises after a line status read
        line_err = 1; tick();
        check("R9 line level sets", 6'h06, 1);
        line_err = 1; lsr_rd = 1; tick();
        check("R9 read while level held", 6'h06, 1);
        lsr_rd = 1; tick();
        check("R9 clears after level drops", 6'h01, 0);

        // R7: xoff vs special clearing
        special = 1; tick();
        check("R7 special sets", 6'h10, 1);
        xon = 1; tick();
        check("R7 xon leaves special", 6'h10, 1);
        lsr_rd = 1; tick();
        check("R7 lsr read clears special", 6'h01, 0);
        xoff = 1; tick();
        lsr_rd = 1; tick();
        check("R7 lsr read leaves xoff", 6'h10, 1);
        xon = 1; tick();
        check("R7 xon clears xoff", 6'h01, 0);

        // R4: identification read that reports another code keeps THR
        overrun = 1; thr_empty = 1; tick();
        iir_rd = 1; tick();
        check("R4 unreported THR kept", 6'h06, 1);
        lsr_rd = 1; tick();
        check("R4 THR now reported", 6'h02, 1);
        thr_wr = 1; tick();
        check("R4 THR write clears", 6'h01, 0);

        // R10: set wins over same-cycle clear
        thr_empty = 1; thr_wr = 1; tick();
        check("R10 set beats clear", 6'h02, 1);
        iir_rd = 1; tick();
        check("R4 reported THR cleared by read", 6'h01, 0);

        // R8: timeout ahead of data, both cleared by one read
        rx_to = 1; rx_avail = 1; tick();
        check("R8 R2 timeout first", 6'h0C, 1);
        rhr_rd = 1; tick();
        check("R8 rhr read clears both", 6'h01, 0);

        // R3: disabling drops a pending source
        modem = 1; tick();
        check("R5 modem sets", 6'h00, 1);
        ier = 6'h00; tick();
        check("R3 disabled quiet", 6'h01, 0);
        modem = 1; tick();
        check("R3 disabled event ignored", 6'h01, 0);
        ier = 6'h3F; tick();
        check("R3 re-enable shows no stale", 6'h01, 0);

        // R6: falling edge does nothing, rising edge raises
        cts_n = 0; tick();
        check("R6 falling edge ignored", 6'h01, 0);
        cts_n = 1; tick();
        check("R6 rising edge raises", 6'h20, 1);
        iir_rd = 1; tick();
        check("R6 read clears flow", 6'h01, 0);

        // R11: reset clears pending
        modem = 1; tick();
        rst = 1; tick(); rst = 0;
        check("R11 reset clears", 6'h01, 0);

        // R2 R3 R5: exhaustive sweep of enables and events
        for (int e = 0; e < 64; e++)
            for (int v = 0; v < 128; v++)
                sweep_one(6'(e), 7'(v));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule